// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts video scanlines and raises an interrupt request toward the CPU once a programmed number of lines has gone by. Software sets it up with byte writes in the top quarter of the CPU address space. One write stores a reload value in a holding register. A second write copies that value into the working counter. A third write arms the request. A fourth write acknowledges a pending request and disarms it.

A single-cycle strobe marks each scanline. On each strobe the counter loads the held value if it is zero, and otherwise counts down by one. If the counter is zero after the strobe while the block is armed, the request output goes high. It stays high until software acknowledges it. The request is registered, so it changes one clock after the strobe or write that causes the change.

Top module: `scanline_irq_counter`

## Requirements
- R1: While reset is high, and on the first clock after it, the request output is 0 and the counter, the held reload value and the armed flag are all 0. A block that has just been reset and is then armed raises the request on its first strobe.
- R2: A write whose address has top three bits 110 and bit 0 equal to 0 stores the data byte as the reload value. It does not change the counter.
- R3: A write whose address has top three bits 110 and bit 0 equal to 1 copies the reload value into the counter on that clock edge.
- R4: On a strobe, a zero counter takes the reload value and a nonzero counter decreases by one.
- R5: The request goes high one clock after a strobe that leaves the counter at zero while the block is armed. With reload value N>0 loaded into the counter, this happens on the Nth strobe. With N=0, it happens on every strobe.
- R6: Once high, the request stays high, across further strobes, until an acknowledge write.
- R7: A write whose address has top three bits 111 and bit 0 equal to 0 clears the request and disarms the block. While disarmed, a counter reaching zero raises no request.
- R8: A write whose address has top three bits 111 and bit 0 equal to 1 arms the block.
- R9: Writes whose address has top bit 0, or top three bits 100 or 101, have no effect.
- R10: When a copy write (R3) and a strobe occur in the same cycle, the copy wins. When an acknowledge write and a strobe that reaches zero occur in the same cycle, the request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | DATA_W | CPU write data |
| line_strobe | input | 1 | One-cycle pulse per scanline |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data. The counter therefore spans the full 0 to 255 range, so the largest period (255 strobes) runs in full alongside the zero-value case that fires on every strobe. Because the address is full width, a write that matches only in bit 0 can be aimed at each region outside the decoded quarter to show it is ignored.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_LATCH  = 3'd1,
    CMD_RELOAD = 3'd2,
    CMD_ACK    = 3'd3,
    CMD_ARM    = 3'd4
  } irq_cmd_e;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output irq_cmd_e          cmd
);
  localparam int TOP = ADDR_W - 1;

  logic [2:0] region;
  logic       unused_mid;

  assign region     = wr_addr[TOP -: 3];
  assign unused_mid = ^wr_addr[TOP-3:1];

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      unique case (region)
        3'b110:  cmd = wr_addr[0] ? CMD_RELOAD : CMD_LATCH;
        3'b111:  cmd = wr_addr[0] ? CMD_ARM    : CMD_ACK;
        default: cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import scanline_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  irq_cmd_e          cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_strobe,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] latch_q,
  output logic              hit
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] step_val;
  logic              take_step;

  assign step_val  = (cnt_q == '0) ? latch_q : cnt_q - ONE;
  assign take_step = line_strobe && (cmd != CMD_RELOAD);
  assign hit       = take_step && (step_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (cmd == CMD_LATCH) begin
      latch_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cmd == CMD_RELOAD) begin
      cnt_q <= latch_q;
    end else if (take_step) begin
      cnt_q <= step_val;
    end
  end
endmodule

// File: rtl/irq_req_ctl.sv
module irq_req_ctl
  import scanline_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_cmd_e cmd,
  input  logic     hit,
  output logic     en_q,
  output logic     irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cmd == CMD_ACK) begin
        en_q  <= 1'b0;
        irq_q <= 1'b0;
      end else begin
        if (cmd == CMD_ARM) en_q <= 1'b1;
        if (hit && en_q)    irq_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_strobe,
  output logic              irq
);
  irq_cmd_e          cmd;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] latch_q;
  logic              hit;
  logic              en_q;

  irq_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  irq_line_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .wr_data     (wr_data),
    .line_strobe (line_strobe),
    .cnt_q       (cnt_q),
    .latch_q     (latch_q),
    .hit         (hit)
  );

  irq_req_ctl u_req (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .hit   (hit),
    .en_q  (en_q),
    .irq_q (irq)
  );
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              line_strobe,
  input logic              irq,
  input logic              en_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] latch_q
);
  logic ack_wr, reload_wr;
  assign ack_wr    = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b111) && !wr_addr[0];
  assign reload_wr = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b110) &&  wr_addr[0];

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!irq && !en_q && cnt_q == '0 && latch_q == '0));

  a_r3_reload_copy: assert property (@(posedge clk) disable iff (rst)
    reload_wr |=> cnt_q == $past(latch_q));

  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && !reload_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DATA_W'(1));

  a_r4_zero_reload: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && !reload_wr && cnt_q == '0) |=> cnt_q == $past(latch_q));

  a_r5_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(line_strobe) && $past(en_q)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_wr) |=> irq);

  a_r7_ack: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> (!irq && !en_q));
endmodule

bind scanline_irq_counter scanline_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .line_strobe (line_strobe),
  .irq         (irq),
  .en_q        (en_q),
  .cnt_q       (cnt_q),
  .latch_q     (latch_q)
);

// File: tb/scanline_irq_counter_tb.sv
module scanline_irq_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // each entry: {reload value, strobe on which the request must first appear}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd5,   8'd5},
    {8'd1,   8'd1},
    {8'd0,   8'd1},
    {8'd12,  8'd12},
    {8'd255, 8'd255},
    {8'd2,   8'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_strobe = 1'b0;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_irq_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_strobe(line_strobe), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); line_strobe = 1'b1;
    @(negedge clk); line_strobe = 1'b0;
  endtask

  task automatic wr_with_strobe(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; line_strobe = 1'b1;
    @(negedge clk); wr_en = 1'b0; line_strobe = 1'b0;
  endtask

  // strobes until the request appears; returns the strobe index, 0 if never
  task automatic first_irq(input int limit, output int at);
    at = 0;
    for (int k = 1; k <= limit; k++) begin
      strobe();
      if (irq) begin at = k; break; end
    end
  endtask

  initial begin
    int at;
    @(negedge clk);
    chk("R1 irq low in reset", irq, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq low after reset", irq, 0);

    // table walk: R3 copy, R4 countdown, R5 period, R8 arm
    for (int i = 0; i < NVEC; i++) begin
      wr(16'hE000, 8'h00);
      wr(16'hC000, VEC[i][15:8]);
      wr(16'hC001, 8'h00);
      wr(16'hE001, 8'h00);
      first_irq(300, at);
      chk($sformatf("R5 R3 R4 period for value %0d", VEC[i][15:8]), at, int'(VEC[i][7:0]));
    end

    // R1: reset value of held register is 0 -> first strobe fires
    do_reset();
    wr(16'hE001, 8'h00);
    strobe();
    chk("R1 zero reload after reset", irq, 1);

    // R2: held write leaves counter at 0, so first strobe reloads 3
    do_reset();
    wr(16'hC000, 8'd3);
    wr(16'hE001, 8'h00);
    first_irq(10, at);
    chk("R2 latch without copy", at, 4);

    // R6: request holds through idle cycles and another strobe (counter -> 3)
    repeat (5) @(negedge clk);
    chk("R6 hold idle", irq, 1);
    strobe();
    chk("R6 hold across strobe", irq, 1);

    // R7: acknowledge clears and disarms; counter 3 -> 0 raises nothing
    wr(16'hE000, 8'h00);
    chk("R7 ack clears", irq, 0);
    repeat (3) strobe();
    chk("R7 disarmed no request", irq, 0);

    // R9: lookalike writes outside the decoded quarter do nothing
    wr(16'h6001, 8'h00);
    wr(16'hA001, 8'h00);
    wr(16'h2001, 8'h00);
    wr(16'h8000, 8'h00);
    repeat (4) strobe();
    chk("R9 ignored writes", irq, 0);

    // R8: arm; counter 0 -> 3,2,1,0 so fourth strobe fires
    wr(16'hE001, 8'h00);
    first_irq(10, at);
    chk("R8 arm", at, 4);

    // R10: copy beats simultaneous strobe
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'd2);
    wr(16'hC001, 8'h00);
    wr(16'hC000, 8'd6);
    wr_with_strobe(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
    first_irq(20, at);
    chk("R10 copy wins over strobe", at, 6);

    // R10: acknowledge beats a simultaneous zero-reaching strobe
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'd1);
    wr(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
    wr_with_strobe(16'hE000, 8'h00);
    chk("R10 ack wins over strobe", irq, 0);
    repeat (3) @(negedge clk);
    chk("R10 stays low", irq, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule